// File: doc/BRIEF.md
# Dual-Clock Random-Source Control Register

This block is the control register of a random-number core whose sampling logic runs on its own clock. Software writes and reads it on the bus clock. It holds four settings: a core shut-off bit, two request bits that each clear one group of error flags in the core, and a 16-bit divider that sets how often the core samples its entropy source. Each setting crosses into the core clock domain through a two-flop synchronizer.

The shut-off bit reads back through a second synchronizer from the core domain. Software knows that a new setting is in force when the value it reads matches the value it wrote. A clear request bit stays at 1 until the core domain has taken the request. The bit then drops by itself, and the core side emits a single-cycle clear pulse.

The core side also generates the sampling clock enable. The enable fires once every divider+1 core clocks. It is silenced while the core is shut off. A new divider value is picked up only at the end of the period in progress.

Top module: `rng_ctrl_xdom`

## Requirements
- R1: After reset, every field is 0 and `rd_data` reads 0. No clear pulse appears. `sample_tick` is high on every core clock, because a divider of 0 means division by 1.
- R2: Bit 0 of the register is the shut-off control: 1 shuts the core off and 0 runs it. While `core_off` is 1, `sample_tick` stays low and the count is held at zero. When the core runs again, ticks resume at the configured spacing.
- R3: A read of bit 0 returns the value held in the core domain, not the value last written. It still shows the old value on the bus cycle after a write. `core_off` already equals the written value once the read-back shows that value.
- R4: Writing 1 to bit 1 (health-flag clear) produces exactly one single-cycle `health_clr` pulse in the core domain. Writing 0 to bit 1 produces no pulse.
- R5: Writing 1 to bit 2 (clock-error-flag clear) produces exactly one single-cycle `clkerr_clr` pulse in the core domain. Writing 0 to bit 2 produces no pulse.
- R6: A clear request bit reads 1 from the bus cycle after the write until the core domain has acknowledged it. It then returns to 0 without any further write.
- R7: The divider field occupies bits 19:4. With value N, `sample_tick` pulses once every N+1 core clocks, from N=0 (every clock) up to N=0xFFFF (every 65536 clocks).
- R8: A divider change written in the middle of a period does not shorten that period. The old spacing completes, and the new spacing applies from the following period.
- R9: A second write of 1 to a clear bit while that bit still reads 1 merges with the pending request and produces no extra pulse.
- R10: The divider field reads back the written value on the bus cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Register read value |
| core_clk | input | 1 | Core-side clock |
| core_rst_n | input | 1 | Core-side asynchronous reset, active low |
| core_off | output | 1 | Shut-off setting as seen by the core |
| health_clr | output | 1 | Single-cycle health-flag clear pulse |
| clkerr_clr | output | 1 | Single-cycle clock-error-flag clear pulse |
| sample_tick | output | 1 | Sampling clock enable |

## Verification
The divider field is checked on the bus cycle right after the write, since it comes straight from a bus register. The read-back of bit 0 needs two core edges and then two bus edges. The bench therefore checks for the old value one bus cycle after the write, and then polls within a bounded window for the new value. A clear pulse arrives about three core clocks after the write, and the pending bit falls a few bus clocks later. A scoreboard queue matches each pulse to the write that caused it, whenever the pulse arrives. A divider change passes through two core sync flops and one stability cycle, and it then waits for the next terminal count. The bench lets that settle, discards the first recorded gap and compares only complete tick gaps. In the mid-period test it expects the old spacing in the gap that was under way when the write landed.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
    // Register field positions (read and write share one layout)
    localparam int OFF_BIT = 0;
    localparam int HLT_BIT = 1;
    localparam int CLK_BIT = 2;
    localparam int DIV_LSB = 4;
endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/flag_clear_link.sv
module flag_clear_link #(
    parameter int STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic req_set,
    output logic pending,
    input  logic core_clk,
    input  logic core_rst_n,
    output logic clr_pulse
);
    // Bus side: request toggle, flipped only when nothing is outstanding
    logic req_d, req_q;
    logic ack_s;
    // Core side: last toggle level taken
    logic seen_d, seen_q;
    logic req_s;

    assign pending = req_q ^ ack_s;

    always_comb begin
        req_d = req_q;
        if (req_set && !pending) req_d = ~req_q;
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) req_q <= 1'b0;
        else            req_q <= req_d;
    end

    xdom_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(core_clk), .rst_n(core_rst_n), .din(req_q), .dout(req_s)
    );

    always_comb begin
        seen_d = req_s;
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) seen_q <= 1'b0;
        else             seen_q <= seen_d;
    end

    assign clr_pulse = req_s ^ seen_q;

    xdom_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .din(seen_q), .dout(ack_s)
    );

    // R4 / R5: a clear pulse lasts exactly one core clock
    a_r4_one_cycle_pulse: assert property (
        @(posedge core_clk) disable iff (!core_rst_n)
        clr_pulse |=> !clr_pulse
    ) else $error("clear pulse longer than one core cycle");

    // R9: the request toggle only moves when no request is outstanding
    a_r9_merge_pending: assert property (
        @(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(req_q) |-> !$past(pending)
    ) else $error("request toggled while one was pending");
endmodule

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         off,
    input  logic [W-1:0] div_in,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
        logic [W-1:0] prev;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    div_stable;
    logic    at_end;

    assign at_end = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d       = st_q;
        st_d.prev  = div_in;
        div_stable = (div_in == st_q.prev);
        if (off) begin
            st_d.cnt = '0;
            if (div_stable) st_d.lim = div_in;
        end else if (at_end) begin
            st_d.cnt = '0;
            if (div_stable) st_d.lim = div_in;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = !off && at_end;

    // R2: counter parked at zero after a shut-off cycle
    a_r2_hold_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        off |=> (st_q.cnt == '0)
    ) else $error("count not parked while shut off");

    // R8: limit only reloads at the end of a period or while shut off
    a_r8_limit_steady: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!off && !at_end) |=> $stable(st_q.lim)
    ) else $error("divider changed mid-period");

    // R7: count never passes the active limit
    a_r7_cnt_range: assert property (
        @(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim
    ) else $error("count beyond limit");
endmodule

// File: rtl/rng_ctrl_xdom.sv
module rng_ctrl_xdom
    import rng_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              core_clk,
    input  logic              core_rst_n,
    output logic              core_off,
    output logic              health_clr,
    output logic              clkerr_clr,
    output logic              sample_tick
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    typedef struct packed {
        logic             off;
        logic [DIV_W-1:0] div;
    } bus_reg_t;

    bus_reg_t reg_d, reg_q;
    logic     off_back;
    logic     hlt_pend, clk_pend;
    logic     hlt_set, clk_set;
    logic [DIV_W-1:0] div_core;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DIV_LSB-1:CLK_BIT+1], wr_data[DATA_W-1:DIV_MSB+1]};

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d.off = wr_data[OFF_BIT];
            reg_d.div = wr_data[DIV_MSB:DIV_LSB];
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) reg_q <= '0;
        else            reg_q <= reg_d;
    end

    assign hlt_set = wr_en && wr_data[HLT_BIT];
    assign clk_set = wr_en && wr_data[CLK_BIT];

    // Settings into the core domain
    xdom_sync #(.W(1), .STAGES(STAGES)) u_off_fwd (
        .clk(core_clk), .rst_n(core_rst_n), .din(reg_q.off), .dout(core_off)
    );
    xdom_sync #(.W(DIV_W), .STAGES(STAGES)) u_div_fwd (
        .clk(core_clk), .rst_n(core_rst_n), .din(reg_q.div), .dout(div_core)
    );
    // Shut-off state back to the bus domain
    xdom_sync #(.W(1), .STAGES(STAGES)) u_off_back (
        .clk(bus_clk), .rst_n(bus_rst_n), .din(core_off), .dout(off_back)
    );

    flag_clear_link #(.STAGES(STAGES)) u_hlt_link (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .req_set(hlt_set),
        .pending(hlt_pend), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .clr_pulse(health_clr)
    );
    flag_clear_link #(.STAGES(STAGES)) u_clk_link (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .req_set(clk_set),
        .pending(clk_pend), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .clr_pulse(clkerr_clr)
    );

    sample_tick_gen #(.W(DIV_W)) u_tick (
        .clk(core_clk), .rst_n(core_rst_n), .off(core_off),
        .div_in(div_core), .tick(sample_tick)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[OFF_BIT]         = off_back;
        rd_data[HLT_BIT]         = hlt_pend;
        rd_data[CLK_BIT]         = clk_pend;
        rd_data[DIV_MSB:DIV_LSB] = reg_q.div;
    end

    // R10: divider field reflects the last write on the next bus cycle
    a_r10_div_readback: assert property (
        @(posedge bus_clk) disable iff (!bus_rst_n)
        wr_en |=> (rd_data[DIV_MSB:DIV_LSB] == $past(wr_data[DIV_MSB:DIV_LSB]))
    ) else $error("divider read-back mismatch");

    // R3: read-back of the shut-off bit never jumps on the write cycle itself
    a_r3_readback_lags: assert property (
        @(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && (wr_data[OFF_BIT] != off_back) && (reg_q.off == off_back))
            |=> (rd_data[OFF_BIT] == $past(off_back))
    ) else $error("shut-off read-back did not lag the write");
endmodule

// File: tb/rng_ctrl_xdom_test.sv
`timescale 1ns/10ps
module rng_ctrl_xdom_test;
    logic        bus_clk = 1'b0, core_clk = 1'b0;
    logic        bus_rst_n = 1'b0, core_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        core_off, health_clr, clkerr_clr, sample_tick;

    int tests = 0, fails = 0;
    int exp_q[$];       // expected clear pulses: 1 = health, 2 = clock error
    int gap_q[$];       // recorded tick spacings
    int hlt_cnt = 0, clk_cnt = 0;
    int since = 0;
    logic        off_sh = 1'b0;
    logic [15:0] div_sh = '0;

    always #4    bus_clk  = ~bus_clk;   // 125 MHz
    always #2.65 core_clk = ~core_clk;  // unrelated core clock

    rng_ctrl_xdom uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .core_off(core_off), .health_clr(health_clr), .clkerr_clr(clkerr_clr),
        .sample_tick(sample_tick)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic hlt, input logic ce);
        word = {12'h0, div_sh, 1'b0, ce, hlt, off_sh};
    endfunction

    task automatic bus_write(input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Monitor: clear pulses popped against the scoreboard
    always @(negedge core_clk) begin
        if (health_clr) begin
            hlt_cnt++;
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected health pulse", 1, 0);
            else begin
                check(exp_q[0] == 1, "R4 health pulse order", 1, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        if (clkerr_clr) begin
            clk_cnt++;
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected clkerr pulse", 2, 0);
            else begin
                check(exp_q[0] == 2, "R5 clkerr pulse order", 2, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        if (sample_tick) begin
            gap_q.push_back(since);
            since = 1;
        end else begin
            since++;
        end
    end

    task automatic wait_core(input int n);
        repeat (n) @(negedge core_clk);
    endtask

    task automatic wait_gaps(input int n);
        while (gap_q.size() < n) @(negedge core_clk);
    endtask

    task automatic measure(input logic [15:0] d, input int n, input string tag);
        div_sh = d;
        bus_write(word(1'b0, 1'b0));
        wait_core(20);
        gap_q.delete();
        wait_gaps(n + 1);
        for (int i = 1; i <= n; i++)
            check(gap_q[i] == int'(d) + 1, tag, gap_q[i], int'(d) + 1);
    endtask

    task automatic clear_req(input int kind, input string tag);
        int bitpos = (kind == 1) ? 1 : 2;
        int guard = 0;
        exp_q.push_back(kind);
        bus_write(word(kind == 1, kind == 2));
        check(rd_data[bitpos] == 1'b1, {tag, " R6 pending after write"}, rd_data[bitpos], 1);
        while (rd_data[bitpos] && guard < 60) begin @(negedge bus_clk); guard++; end
        check(rd_data[bitpos] == 1'b0, {tag, " R6 self-clear"}, rd_data[bitpos], 0);
        wait_core(10);
        check(exp_q.size() == 0, {tag, " pulse delivered"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (195000) @(posedge bus_clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int h0, c0, guard, ticks;
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1'b1; core_rst_n = 1'b1;
        wait_core(4);
        // R1: reset state
        check(rd_data == 32'h0, "R1 reset read", rd_data, 0);
        check(hlt_cnt == 0 && clk_cnt == 0, "R1 no pulses", hlt_cnt + clk_cnt, 0);
        gap_q.delete();
        wait_gaps(8);
        for (int i = 1; i < 8; i++) check(gap_q[i] == 1, "R1 tick every cycle", gap_q[i], 1);

        // R10 and R7
        div_sh = 16'd3;
        bus_write(word(1'b0, 1'b0));
        check(rd_data[19:4] == 16'd3, "R10 divider read-back", rd_data[19:4], 3);
        measure(16'd3, 3, "R7 div 3");
        measure(16'd1, 3, "R7 div 1");
        measure(16'd0, 4, "R7 div 0");
        measure(16'd5, 2, "R7 div 5");

        // R3 / R2: shut-off
        off_sh = 1'b1;
        bus_write(word(1'b0, 1'b0));
        check(rd_data[0] == 1'b0, "R3 read-back lags write", rd_data[0], 0);
        guard = 0;
        while (!rd_data[0] && guard < 60) begin @(negedge bus_clk); guard++; end
        check(rd_data[0] == 1'b1, "R3 read-back reaches 1", rd_data[0], 1);
        check(core_off == 1'b1, "R3 core sees shut-off", core_off, 1);
        ticks = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge core_clk);
            if (sample_tick) ticks++;
        end
        check(ticks == 0, "R2 no ticks while off", ticks, 0);
        off_sh = 1'b0;
        bus_write(word(1'b0, 1'b0));
        check(rd_data[0] == 1'b1, "R3 read-back lags re-enable", rd_data[0], 1);
        guard = 0;
        while (rd_data[0] && guard < 60) begin @(negedge bus_clk); guard++; end
        check(rd_data[0] == 1'b0 && core_off == 1'b0, "R3 re-enable applied", rd_data[0], 0);
        gap_q.delete();
        wait_gaps(3);
        check(gap_q[1] == 6 && gap_q[2] == 6, "R2 ticks resume", gap_q[1], 6);

        // R4 / R5 / R6
        clear_req(1, "R4 health");
        clear_req(2, "R5 clkerr");
        h0 = hlt_cnt; c0 = clk_cnt;
        bus_write(word(1'b0, 1'b0));
        wait_core(30);
        check(hlt_cnt == h0, "R4 write 0 no pulse", hlt_cnt, h0);
        check(clk_cnt == c0, "R5 write 0 no pulse", clk_cnt, c0);
        check(rd_data[2:1] == 2'b00, "R6 bits stay clear", rd_data[2:1], 0);

        // R9: back-to-back writes merge
        h0 = hlt_cnt;
        exp_q.push_back(1);
        bus_write(word(1'b1, 1'b0));
        bus_write(word(1'b1, 1'b0));
        repeat (60) @(negedge bus_clk);
        check(hlt_cnt == h0 + 1, "R9 merged request", hlt_cnt, h0 + 1);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

        // R8: mid-period change keeps the running period
        measure(16'd9, 1, "R8 div 9 setup");
        gap_q.delete();
        wait_gaps(1);
        div_sh = 16'd2;
        bus_write(word(1'b0, 1'b0));
        wait_gaps(3);
        check(gap_q[1] == 10, "R8 running period kept", gap_q[1], 10);
        check(gap_q[2] == 3, "R8 new period after", gap_q[2], 3);

        // R7 largest divider
        measure(16'hFFFF, 1, "R7 div 0xFFFF");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule